// File: doc/BRIEF.md
# Serial Test-Pattern Receive Checker

This block sits on the receive side of a bit error rate test path. It takes a serial bit stream qualified by a receive enable and locks onto the pattern the far-end generator sends. That pattern is either a pseudorandom sequence from a shift register of up to 32 stages with programmable feedback taps, or a user pattern of 1 to 32 bits repeated end to end. The block needs no seed and no copy of the user pattern. It fills its local shift register from the line, then predicts every later bit itself. While locked it compares each received bit with its prediction and accumulates a bit count and an error count.

Synchronisation is a three-state machine. In SEARCH, received bits are shifted straight into the predictor. After 32 enabled bits the transition *load done* moves to VERIFY. In VERIFY each enabled bit is compared with the prediction. A mismatch takes the transition *verify miss* back to SEARCH, which starts a fresh load. Thirty-two consecutive matches take the transition *run complete* to LOCKED. In LOCKED the predictor runs free on its own predictions, so isolated line errors do not disturb it. Compared bits are split into blocks of 64, counted from lock. If a sixth error arrives inside one block, the transition *loss* returns to SEARCH and a one-cycle loss flag is raised.

Software reads results through a snapshot strobe. The strobe copies both live counters into holding registers and zeroes the live counters in the same cycle, so no bit falls between two readings. The receive enable gaps the clock: while it is low, nothing is compared, counted or advanced.

Top module: `bert_rx_checker`

## Requirements
- R1: After reset, `in_sync` and `sync_lost` are 0 and both held counts are 0.
- R2: The predictor keeps the received history with the newest bit at bit 0. In pseudorandom mode (`cfg_repeat`=0) the predicted bit is the XOR of the history bits selected by ones in `cfg_taps`. In repeat mode (`cfg_repeat`=1) the predicted bit is the bit received L bits earlier, where `cfg_len_m1` holds L-1.
- R3: From SEARCH, `in_sync` rises right after the 64th enabled bit of a clean stream (32 loaded, 32 matched). A mismatch during VERIFY restarts the 32-bit load from the next bit.
- R4: While locked, each enabled bit adds one to the bit count, and each mismatch also adds one to the error count. Up to 5 errors within one 64-bit block leave the lock in place.
- R5: While locked, the 6th error inside one 64-bit block (blocks counted from lock) drops `in_sync` after that bit. `sync_lost` is 1 for exactly that one cycle. The bit that causes the loss is itself counted. Errors in different blocks do not add up.
- R6: While `rx_en` is 0, no bit is compared, counted, loaded or used to advance the state, whatever `rx_bit` carries.
- R7: Bits received while not locked are not counted.
- R8: The counters are CNT_W bits wide (32 by default). Each stops at all ones instead of wrapping.
- R9: A cycle with `snap`=1 loads each held count with the live count plus any bit counted in that same cycle, and restarts the live counts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive bit enable (gap clock) |
| rx_bit | input | 1 | Received serial data |
| cfg_repeat | input | 1 | 0 = pseudorandom, 1 = repeating user pattern |
| cfg_len_m1 | input | $clog2(PAT_W) | Repeat length minus one |
| cfg_taps | input | PAT_W | Feedback tap mask for pseudorandom mode |
| snap | input | 1 | Copy live counts to holding registers and clear them |
| in_sync | output | 1 | Pattern lock indicator |
| sync_lost | output | 1 | One-cycle pulse on each exit from lock |
| bits_held | output | CNT_W | Held bit count |
| errs_held | output | CNT_W | Held error count |

## Verification
A 7-stage pseudorandom stream checks lock timing, the free-running prediction and error counting. A 5-bit repeating pattern shows that the repeat path predicts from the programmed length and not from the taps. A lone error early in VERIFY is told apart from a locked-state error because it delays lock by a full 64 bits. Error bursts are placed so that 5 errors in one block, 3+3 errors straddling a block edge, and 6 errors in one block each give a different lock outcome. Gaps carrying inverted data, a snapshot taken together with a counted bit, and a long clean run against a narrowed counter cover the gap, snapshot and saturation rules.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;
    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } sync_state_t;
endpackage

// File: rtl/bert_rx_predictor.sv
module bert_rx_predictor #(
    parameter int PAT_W = 32,
    localparam int LW = $clog2(PAT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             take_line,
    input  logic             rx_bit,
    input  logic             cfg_repeat,
    input  logic [LW-1:0]    cfg_len_m1,
    input  logic [PAT_W-1:0] cfg_taps,
    output logic             pred_bit
);
    logic [PAT_W-1:0] hist_q;

    // Newest bit at index 0; prediction from taps or from the bit L back.
    always_comb begin
        if (cfg_repeat) pred_bit = hist_q[cfg_len_m1];
        else            pred_bit = ^(hist_q & cfg_taps);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[PAT_W-2:0], take_line ? rx_bit : pred_bit};
    end
endmodule

// File: rtl/bert_rx_sync_fsm.sv
module bert_rx_sync_fsm
    import bert_rx_pkg::*;
#(
    parameter int PAT_W     = 32,
    parameter int LOCK_RUN  = 32,
    parameter int WIN_LEN   = 64,
    parameter int ERR_LIMIT = 6,
    localparam int RUN_MAX  = (PAT_W > LOCK_RUN) ? PAT_W : LOCK_RUN,
    localparam int RCW      = $clog2(RUN_MAX + 1),
    localparam int WCW      = $clog2(WIN_LEN + 1),
    localparam int ECW      = $clog2(ERR_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic mismatch,
    output logic in_sync,
    output logic sync_lost,
    output logic take_line,
    output logic count_en
);
    localparam logic [RCW-1:0] LOAD_LAST = RCW'(PAT_W - 1);
    localparam logic [RCW-1:0] RUN_LAST  = RCW'(LOCK_RUN - 1);
    localparam logic [WCW-1:0] WIN_LAST  = WCW'(WIN_LEN - 1);
    localparam logic [ECW-1:0] ERR_MAX   = ECW'(ERR_LIMIT);

    sync_state_t    state_q, state_d;
    logic [RCW-1:0] run_q, run_d;
    logic [WCW-1:0] win_q, win_d;
    logic [ECW-1:0] errs_q, errs_d, errs_inc;
    logic           lose;

    assign errs_inc = errs_q + {{(ECW-1){1'b0}}, mismatch};

    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        win_d   = win_q;
        errs_d  = errs_q;
        lose    = 1'b0;
        if (bit_en) begin
            unique case (state_q)
                ST_SEARCH: begin
                    if (run_q == LOAD_LAST) begin
                        state_d = ST_VERIFY;          // load done
                        run_d   = '0;
                    end else begin
                        run_d = run_q + 1'b1;
                    end
                end
                ST_VERIFY: begin
                    if (mismatch) begin
                        state_d = ST_SEARCH;          // verify miss
                        run_d   = '0;
                    end else if (run_q == RUN_LAST) begin
                        state_d = ST_LOCKED;          // run complete
                        run_d   = '0;
                        win_d   = '0;
                        errs_d  = '0;
                    end else begin
                        run_d = run_q + 1'b1;
                    end
                end
                ST_LOCKED: begin
                    if (errs_inc == ERR_MAX) begin
                        state_d = ST_SEARCH;          // loss
                        run_d   = '0;
                        lose    = 1'b1;
                    end else if (win_q == WIN_LAST) begin
                        win_d  = '0;
                        errs_d = '0;
                    end else begin
                        win_d  = win_q + 1'b1;
                        errs_d = errs_inc;
                    end
                end
                default: state_d = ST_SEARCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEARCH;
            run_q   <= '0;
            win_q   <= '0;
            errs_q  <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            win_q   <= win_d;
            errs_q  <= errs_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_lost <= 1'b0;
        else        sync_lost <= lose;
    end

    assign in_sync   = (state_q == ST_LOCKED);
    assign take_line = (state_q != ST_LOCKED);
    assign count_en  = bit_en && (state_q == ST_LOCKED);
endmodule

// File: rtl/bert_rx_counters.sv
module bert_rx_counters #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             mismatch,
    input  logic             snap,
    output logic [CNT_W-1:0] bit_live,
    output logic [CNT_W-1:0] err_live,
    output logic [CNT_W-1:0] bit_hold,
    output logic [CNT_W-1:0] err_hold
);
    logic [CNT_W-1:0] bit_nxt, err_nxt;

    always_comb begin
        bit_nxt = bit_live;
        err_nxt = err_live;
        if (count_en && (bit_live != '1))             bit_nxt = bit_live + CNT_W'(1);
        if (count_en && mismatch && (err_live != '1)) err_nxt = err_live + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_live <= '0;
            err_live <= '0;
            bit_hold <= '0;
            err_hold <= '0;
        end else if (snap) begin
            bit_hold <= bit_nxt;
            err_hold <= err_nxt;
            bit_live <= '0;
            err_live <= '0;
        end else begin
            bit_live <= bit_nxt;
            err_live <= err_nxt;
        end
    end
endmodule

// File: rtl/bert_rx_checker.sv
module bert_rx_checker #(
    parameter int PAT_W     = 32,
    parameter int CNT_W     = 32,
    parameter int LOCK_RUN  = 32,
    parameter int WIN_LEN   = 64,
    parameter int ERR_LIMIT = 6,
    localparam int LW       = $clog2(PAT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             rx_bit,
    input  logic             cfg_repeat,
    input  logic [LW-1:0]    cfg_len_m1,
    input  logic [PAT_W-1:0] cfg_taps,
    input  logic             snap,
    output logic             in_sync,
    output logic             sync_lost,
    output logic [CNT_W-1:0] bits_held,
    output logic [CNT_W-1:0] errs_held
);
    logic             pred_bit, mismatch, take_line, count_en;
    logic [CNT_W-1:0] bit_live, err_live;

    assign mismatch = rx_bit ^ pred_bit;

    bert_rx_predictor #(.PAT_W(PAT_W)) u_pred (
        .clk(clk), .rst_n(rst_n), .shift_en(rx_en), .take_line(take_line),
        .rx_bit(rx_bit), .cfg_repeat(cfg_repeat), .cfg_len_m1(cfg_len_m1),
        .cfg_taps(cfg_taps), .pred_bit(pred_bit)
    );

    bert_rx_sync_fsm #(
        .PAT_W(PAT_W), .LOCK_RUN(LOCK_RUN), .WIN_LEN(WIN_LEN), .ERR_LIMIT(ERR_LIMIT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .bit_en(rx_en), .mismatch(mismatch),
        .in_sync(in_sync), .sync_lost(sync_lost), .take_line(take_line),
        .count_en(count_en)
    );

    bert_rx_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .count_en(count_en), .mismatch(mismatch),
        .snap(snap), .bit_live(bit_live), .err_live(err_live),
        .bit_hold(bits_held), .err_hold(errs_held)
    );
endmodule

// File: rtl/bert_rx_checker_sva.sv
module bert_rx_checker_sva #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic             snap,
    input logic             in_sync,
    input logic             sync_lost,
    input logic [CNT_W-1:0] bit_live,
    input logic [CNT_W-1:0] err_live
);
    AST_ERR_LE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        err_live <= bit_live);                                                // R4
    AST_LOSS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_lost |-> (!in_sync && $past(in_sync)));                          // R5
    AST_LOSS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_lost |=> !sync_lost);                                            // R5
    AST_GAP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !snap) |=> ($stable(bit_live) && $stable(err_live)));      // R6
    AST_GAP_HOLD_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> $stable(in_sync));                                         // R6
    AST_NO_COUNT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_sync && !snap) |=> $stable(bit_live));                           // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((bit_live == '1) && !snap) |=> (bit_live == '1));                    // R8
    AST_SNAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> ((bit_live == '0) && (err_live == '0)));                     // R9
endmodule

bind bert_rx_checker bert_rx_checker_sva #(.CNT_W(CNT_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .snap(snap), .in_sync(in_sync),
    .sync_lost(sync_lost), .bit_live(bit_live), .err_live(err_live)
);

// File: tb/bert_rx_checker_test.sv
`timescale 1ns/1ps
module bert_rx_checker_test;
    localparam int PW = 32;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_en = 1'b0;
    logic          rx_bit = 1'b0;
    logic          cfg_repeat = 1'b0;
    logic [4:0]    cfg_len_m1 = 5'd0;
    logic [PW-1:0] cfg_taps = 32'h60;
    logic          snap = 1'b0;
    logic          in_sync, sync_lost;
    logic [CW-1:0] bits_held, errs_held;

    int checks = 0;
    int errors = 0;

    logic [31:0] gen = 32'h1;
    logic [4:0]  rep_pat = 5'b01101;
    int          rep_idx = 0;

    always #2 clk = ~clk;

    bert_rx_checker #(.PAT_W(PW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit),
        .cfg_repeat(cfg_repeat), .cfg_len_m1(cfg_len_m1), .cfg_taps(cfg_taps),
        .snap(snap), .in_sync(in_sync), .sync_lost(sync_lost),
        .bits_held(bits_held), .errs_held(errs_held)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic next_bit();
        logic b;
        if (cfg_repeat) begin
            b = rep_pat[rep_idx];
            rep_idx = (rep_idx + 1) % (int'(cfg_len_m1) + 1);
        end else begin
            b = ^(gen & cfg_taps);
            gen = {gen[30:0], b};
        end
        return b;
    endfunction

    task automatic drive(input logic en, input logic b, input logic s);
        @(negedge clk);
        rx_en = en; rx_bit = b; snap = s;
        @(posedge clk);
        #1;
        rx_en = 1'b0; snap = 1'b0;
    endtask

    task automatic send(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, next_bit(), 1'b0);
    endtask

    task automatic send_err();
        drive(1'b1, ~next_bit(), 1'b0);
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, ~rx_bit, 1'b0);
    endtask

    task automatic take_snap();
        drive(1'b0, 1'b0, 1'b1);
    endtask

    task automatic do_reset(input logic rep);
        @(negedge clk);
        rst_n = 1'b0; cfg_repeat = rep; gen = 32'h1; rep_idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        @(posedge clk); #1;
        check("R1 in_sync", in_sync, 0);
        check("R1 sync_lost", sync_lost, 0);
        check("R1 bits_held", bits_held, 0);
        check("R1 errs_held", errs_held, 0);
    endtask

    task automatic t_lock_prbs();
        do_reset(1'b0);
        send(63);
        check("R3 not locked at 63", in_sync, 0);
        send(1);
        check("R3 locked at 64", in_sync, 1);
        send(100);
        take_snap();
        check("R2 R7 bit count", bits_held, 100);
        check("R2 error count clean", errs_held, 0);
    endtask

    task automatic t_verify_restart();
        do_reset(1'b0);
        send(40);
        send_err();
        send(63);
        check("R3 restart not yet locked", in_sync, 0);
        send(1);
        check("R3 restart locked", in_sync, 1);
    endtask

    task automatic t_five_errors();
        do_reset(1'b0);
        send(64);
        for (int i = 0; i < 5; i++) begin send(10); send_err(); end
        check("R4 lock kept after 5", in_sync, 1);
        take_snap();
        check("R4 bits", bits_held, 55);
        check("R4 errors", errs_held, 5);
    endtask

    task automatic t_block_edge();
        do_reset(1'b0);
        send(64);
        send(60);
        repeat (3) send_err();
        send(1);
        repeat (3) send_err();
        check("R5 split errors keep lock", in_sync, 1);
        take_snap();
        check("R5 split bits", bits_held, 67);
        check("R5 split errors", errs_held, 6);
    endtask

    task automatic t_loss();
        do_reset(1'b0);
        send(64);
        repeat (5) send_err();
        check("R5 locked before 6th", in_sync, 1);
        check("R5 no pulse before 6th", sync_lost, 0);
        send_err();
        check("R5 lock dropped", in_sync, 0);
        check("R5 loss pulse", sync_lost, 1);
        gap(1);
        check("R5 pulse one cycle", sync_lost, 0);
        send(5);
        take_snap();
        check("R5 R7 bits incl 6th", bits_held, 6);
        check("R5 errors incl 6th", errs_held, 6);
    endtask

    task automatic t_gap();
        do_reset(1'b0);
        send(30);
        gap(10);
        send(33);
        check("R6 gaps not loaded", in_sync, 0);
        send(1);
        check("R6 lock after 64 enabled", in_sync, 1);
        for (int i = 0; i < 20; i++) begin send(1); gap(2); end
        take_snap();
        check("R6 bits with gaps", bits_held, 20);
        check("R6 gap data ignored", errs_held, 0);
    endtask

    task automatic t_repeat();
        do_reset(1'b1);
        cfg_len_m1 = 5'd4;
        send(64);
        check("R2 repeat locked", in_sync, 1);
        send(50);
        send_err();
        take_snap();
        check("R2 repeat bits", bits_held, 51);
        check("R2 repeat errors", errs_held, 1);
        cfg_repeat = 1'b0;
    endtask

    task automatic t_snap_same();
        do_reset(1'b0);
        send(64);
        send(10);
        drive(1'b1, next_bit(), 1'b1);
        check("R9 snap includes same-cycle bit", bits_held, 11);
        send(7);
        take_snap();
        check("R9 live cleared by snap", bits_held, 7);
    endtask

    task automatic t_sat();
        do_reset(1'b0);
        send(64);
        send(1100);
        take_snap();
        check("R8 saturated bits", bits_held, 1023);
        check("R8 errors zero", errs_held, 0);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_lock_prbs();
        t_verify_restart();
        t_five_errors();
        t_block_edge();
        t_loss();
        t_gap();
        t_repeat();
        t_snap_same();
        t_sat();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule